// File: doc/BRIEF.md
# Pipelined SPI Register-Access Slave

This block lets an external SPI master read and write a small bank of 16-bit registers through fixed 16-bit frames. Every frame carries a direction flag, a 7-bit register address and an 8-bit payload. A read is split over two frames: the request goes out in one frame, and the addressed register comes back during the next one. Because the link is full duplex, the frame that returns one register can also carry the next request. A master can therefore stream reads back to back, and it can poll a single address and get fresh data on every frame.

The serial pins are sampled from a system clock that runs at least eight times faster than SCLK. SCLK, chip select and the serial input each pass through a two-flop synchroniser. The bank holds three read-only data words, captured from ports on a sample strobe, and a data-ready pulse marks each new sample. It also holds a parameterised set of writable byte registers, and their contents are presented on a flat output.

Top module: `spi_regfile_slave`

## Requirements
- R1: A frame is 16 SCLK bits in SPI mode 3, most significant bit first, with cs_n low for the whole frame. Bit 15 is the direction (0 = read, 1 = write), bits 14:8 are the register address and bits 7:0 are the write byte.
- R2: When a complete read frame is followed by another frame, that next frame shifts out the 16-bit contents of the requested register on miso, most significant bit first. The first bit is presented before the first SCLK falling edge, and the word is captured when that frame starts.
- R3: The frame that returns a reply may itself be a read request. Reading the same address repeatedly returns the value the register holds at the start of each reply frame.
- R4: miso_oe is high during a frame only if the previous frame was a complete 16-bit read. After a write frame or after a partial frame it stays low.
- R5: miso_oe is low whenever cs_n is high. This is checked once the synchroniser delay has passed.
- R6: Address 0x06 returns smp_rate, address 0x04 returns smp_ext and address 0x02 returns smp_temp. All three are captured together on a cycle in which smp_strobe is high.
- R7: data_rdy is high for exactly the one clock cycle that follows each cycle in which smp_strobe is high.
- R8: A complete write frame to address RW_BASE+k (k < RW_COUNT) sets byte k of cfg_out (bits 8k+7:8k) to the frame's low byte once cs_n rises. A read of that address returns {8'h00, byte}. After reset all bytes are zero.
- R9: Writes to the read-only addresses 0x06, 0x04 and 0x02, and writes to unmapped addresses, change nothing.
- R10: A read of an address that maps to no register returns 0x0000, and miso_oe is still high.
- R11: A frame that ends with a bit count other than 16 is discarded. It performs no write and leaves no read request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, idles high |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for miso (low means high impedance) |
| smp_strobe | input | 1 | New sample present on the data ports |
| smp_rate | input | 16 | Primary rate word |
| smp_ext | input | 16 | Extended-resolution rate word |
| smp_temp | input | 16 | Temperature word |
| data_rdy | output | 1 | One-cycle pulse after a sample is captured |
| cfg_out | output | 8*RW_COUNT | Writable byte registers, byte k at bits 8k+7:8k |

## Verification
The bench goes after the pipeline's memory of the previous frame. It checks that the very first read after reset and any frame that follows a write or a truncated frame leave miso undriven. A design that kept a stale request would drive old data there. Repeated polling of one address with samples changing between frames exposes a design that snapshots the reply at request time rather than at reply time. Writes aimed at read-only and unmapped addresses, and a truncated write frame, are followed by reads and by a check of cfg_out, which catches a decoder that writes anywhere or commits partial frames.

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave #(
  parameter logic [6:0] ADDR_RATE = 7'h06,
  parameter logic [6:0] ADDR_EXT  = 7'h04,
  parameter logic [6:0] ADDR_TEMP = 7'h02,
  parameter logic [6:0] RW_BASE   = 7'h10,
  parameter int         RW_COUNT  = 4,
  localparam int        CFG_W     = 8 * RW_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  output logic             miso,
  output logic             miso_oe,
  input  logic             smp_strobe,
  input  logic [15:0]      smp_rate,
  input  logic [15:0]      smp_ext,
  input  logic [15:0]      smp_temp,
  output logic             data_rdy,
  output logic [CFG_W-1:0] cfg_out
);

  logic [2:0]       sck_p, cs_p;
  logic [1:0]       mosi_p;
  logic [15:0]      rx_sr, tx_sr;
  logic [4:0]       nbits;
  logic             rd_pend, drive;
  logic [6:0]       rd_addr;
  logic [15:0]      rate_q, ext_q, temp_q, rd_word;
  logic [CFG_W-1:0] cfg_q;

  wire cs_idle  = cs_p[1];
  wire cs_start = ~cs_p[1] & cs_p[2];
  wire cs_end   = cs_p[1] & ~cs_p[2];
  wire sck_rise = sck_p[1] & ~sck_p[2];
  wire sck_fall = ~sck_p[1] & sck_p[2];
  wire full     = (nbits == 5'd16);

  assign miso     = tx_sr[15];
  assign miso_oe  = drive & ~cs_idle;
  assign cfg_out  = cfg_q;

  always_comb begin
    rd_word = 16'h0000;
    if (rd_addr == ADDR_RATE)      rd_word = rate_q;
    else if (rd_addr == ADDR_EXT)  rd_word = ext_q;
    else if (rd_addr == ADDR_TEMP) rd_word = temp_q;
    for (int k = 0; k < RW_COUNT; k++)
      if (rd_addr == 7'(int'(RW_BASE) + k)) rd_word = {8'h00, cfg_q[8*k +: 8]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '1;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[1:0], sclk};
      cs_p   <= {cs_p[1:0], cs_n};
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr   <= '0;
      tx_sr   <= '0;
      nbits   <= '0;
      drive   <= 1'b0;
      rd_pend <= 1'b0;
      rd_addr <= '0;
      cfg_q   <= '0;
    end else begin
      if (cs_idle) begin
        nbits <= '0;
        drive <= 1'b0;
      end else if (cs_start) begin
        tx_sr <= rd_word;
        drive <= rd_pend;
        nbits <= '0;
      end else begin
        if (sck_rise) begin
          rx_sr <= {rx_sr[14:0], mosi_p[1]};
          nbits <= (nbits == 5'd17) ? nbits : nbits + 5'd1;
        end
        if (sck_fall && nbits != 5'd0)
          tx_sr <= {tx_sr[14:0], 1'b0};
      end
      if (cs_end) begin
        rd_pend <= full & ~rx_sr[15];
        rd_addr <= rx_sr[14:8];
        if (full && rx_sr[15])
          for (int k = 0; k < RW_COUNT; k++)
            if (rx_sr[14:8] == 7'(int'(RW_BASE) + k)) cfg_q[8*k +: 8] <= rx_sr[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q   <= '0;
      ext_q    <= '0;
      temp_q   <= '0;
      data_rdy <= 1'b0;
    end else begin
      data_rdy <= smp_strobe;
      if (smp_strobe) begin
        rate_q <= smp_rate;
        ext_q  <= smp_ext;
        temp_q <= smp_temp;
      end
    end
  end

endmodule

// File: rtl/spi_regfile_slave_chk.sv
module spi_regfile_slave_chk #(
  parameter int CFG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             miso_oe,
  input logic             smp_strobe,
  input logic             data_rdy,
  input logic [CFG_W-1:0] cfg_out
);

  p_oe_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_oe);

  p_oe_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> !$past(cs_n, 2));

  p_rdy_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |=> data_rdy);

  p_rdy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_strobe |=> !data_rdy);

  p_cfg_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_out) |-> $past(cs_n, 2));

endmodule

bind spi_regfile_slave spi_regfile_slave_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso_oe(miso_oe),
  .smp_strobe(smp_strobe), .data_rdy(data_rdy), .cfg_out(cfg_out)
);

// File: tb/spi_regfile_slave_test.sv
`timescale 1ns/1ps
module spi_regfile_slave_test;
  localparam int RWN = 4;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic smp_strobe = 1'b0;
  logic [15:0] smp_rate = '0, smp_ext = '0, smp_temp = '0;
  logic miso, miso_oe, data_rdy;
  logic [8*RWN-1:0] cfg_out;

  always #2.5 clk = ~clk;

  spi_regfile_slave uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .smp_strobe(smp_strobe),
    .smp_rate(smp_rate), .smp_ext(smp_ext), .smp_temp(smp_temp),
    .data_rdy(data_rdy), .cfg_out(cfg_out)
  );

  int checks = 0, fails = 0;
  bit m_pend = 0;
  int m_addr = 0;
  logic [15:0] m_rate = 0, m_ext = 0, m_temp = 0;
  logic [7:0] m_cfg [RWN] = '{default: 8'h00};
  logic exp_rdy = 1'b0;
  int idle = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] m_value(input int a);
    if (a == 6) return m_rate;
    if (a == 4) return m_ext;
    if (a == 2) return m_temp;
    if (a >= 16 && a < 16 + RWN) return {8'h00, m_cfg[a-16]};
    return 16'h0000;
  endfunction

  function automatic logic [8*RWN-1:0] m_cfg_flat();
    logic [8*RWN-1:0] v;
    for (int k = 0; k < RWN; k++) v[8*k +: 8] = m_cfg[k];
    return v;
  endfunction

  always @(posedge clk) begin
    exp_rdy <= smp_strobe;
    idle <= cs_n ? idle + 1 : 0;
  end

  always @(negedge clk) if (rst_n) begin
    chk(data_rdy == exp_rdy, "R7", "data_rdy", data_rdy, exp_rdy);
    if (idle >= 4) chk(!miso_oe, "R5", "oe while deselected", miso_oe, 0);
    if (idle >= 6) chk(cfg_out == m_cfg_flat(), "R8/R9", "cfg_out", cfg_out, m_cfg_flat());
  end

  task automatic sample(input logic [15:0] r, input logic [15:0] e, input logic [15:0] t);
    @(negedge clk);
    smp_rate = r; smp_ext = e; smp_temp = t; smp_strobe = 1'b1;
    @(negedge clk);
    smp_strobe = 1'b0;
    m_rate = r; m_ext = e; m_temp = t;
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] tx, input int n, input string req);
    logic [15:0] rx = '0;
    bit oe_all = 1, oe_any = 0;
    bit exp_oe = m_pend;
    logic [15:0] exp_w = m_value(m_addr);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      mosi = tx[15-i];
      repeat (HALF) @(negedge clk);
      rx = {rx[14:0], miso};
      oe_all &= miso_oe;
      oe_any |= miso_oe;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    if (exp_oe) chk(oe_all, req, "miso_oe during reply", oe_all, 1);
    else        chk(!oe_any, req, "miso_oe without prior read", oe_any, 0);
    if (exp_oe && n == 16) chk(rx == exp_w, req, "reply word", rx, exp_w);
    if (n == 16 && !tx[15]) begin
      m_pend = 1; m_addr = int'(tx[14:8]);
    end else begin
      m_pend = 0;
      if (n == 16 && tx[14:8] >= 16 && tx[14:8] < 16 + RWN) m_cfg[tx[14:8]-16] = tx[7:0];
    end
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(!miso_oe, "R5", "reset oe", miso_oe, 0);
    chk(!data_rdy, "R7", "reset data_rdy", data_rdy, 0);
    chk(cfg_out == '0, "R8", "reset cfg", cfg_out, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    sample(16'hF9DA, 16'h1357, 16'h0ABC);
    xfer(16'h0600, 16, "R4 first read after reset");
    xfer(16'h0400, 16, "R2 R6 rate at 0x06");
    xfer(16'h0200, 16, "R2 R6 ext at 0x04");
    xfer(16'h0600, 16, "R1 R6 temp at 0x02");
    sample(16'h8001, 16'h2468, 16'h0F0F);
    xfer(16'h0600, 16, "R3 repeated poll 1");
    sample(16'h7FFE, 16'h1111, 16'h2222);
    xfer(16'h9055, 16, "R3 repeated poll 2");
    xfer(16'h93A7, 16, "R4 after write");
    xfer(16'h1000, 16, "R4 after write 2");
    xfer(16'h1300, 16, "R8 read byte 0");
    xfer(16'h7F00, 16, "R8 read byte 3");
    xfer(16'h8611, 16, "R10 unmapped read");
    xfer(16'h8A33, 16, "R4 after ro write");
    xfer(16'h0600, 16, "R4 after unmapped write");
    xfer(16'h0400, 16, "R9 ro word kept");
    xfer(16'h9122, 8, "R11 partial write");
    xfer(16'h0000, 16, "R11 no pending after partial");
    xfer(16'h1100, 16, "R10 read at 0x00");
    xfer(16'h0000, 16, "R11 byte 1 untouched");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule